// File: doc/BRIEF.md
# Control-Register Port Write Sequencer

This block performs one write into a PHY's internal control-register space over a narrow strobe-and-acknowledge port. A client presents an address and a data value and pulses a start input. The block then runs three four-phase handshakes back to back: it captures the address, captures the data, and commits the write. Each handshake raises one command strobe next to the value and waits for the PHY to raise its acknowledge. It then drops the strobe, keeps the value, and waits for the acknowledge to fall.

Both acknowledge waits in every handshake are bounded. A poll tick is derived from the system clock by a divider (`TICK_DIV` cycles per tick, one microsecond by default at 50 MHz). A wait gives up after `POLL_LIMIT` ticks. A timeout ends the transaction with an error pulse, and no later phase is issued. A successful commit ends with a done pulse. `busy_o` covers the whole transaction, and start pulses that arrive during it are dropped.

Top module: `crp_write_master`

## Requirements
- R1: The outgoing word `cr_word_o` (VAL_W+4 bits) carries the value at bits [VAL_W+1:2], the address-capture strobe at bit 0, the data-capture strobe at bit 1, a read strobe at bit VAL_W+2 that is always 0, and the write strobe at bit VAL_W+3. At most one strobe is high at a time. The word is all zero while idle.
- R2: A transaction runs address capture first, then data capture, then the write commit. The commit presents the data value again, and done is reported only after the commit.
- R3: Each capture handshake is preceded by exactly one clock cycle in which the value is driven with no strobe. The commit follows data capture with no such cycle.
- R4: In a handshake, the strobe stays high until the acknowledge is seen high. The strobe then drops, and the value alone stays on the word until the acknowledge is seen low.
- R5: Each acknowledge wait lasts at most POLL_LIMIT*TICK_DIV clock cycles. An acknowledge that is first seen in the last cycle of that window still completes the handshake.
- R6: A wait that runs out ends the transaction with an error pulse and the word returns to zero in the same cycle. No later strobe is issued.
- R7: `busy_o` is high from the cycle after an accepted start until the cycle in which done or error pulses. It is low in that cycle. `done_o` and `err_o` are single-cycle pulses and are never high together.
- R8: A start pulse that arrives while busy is ignored. The running transaction keeps the address and data captured at its own start, and no second transaction follows.
- R9: After reset the word is zero and busy, done and error are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start pulse, sampled when idle |
| addr_i | input | VAL_W | Register address, captured at start |
| data_i | input | VAL_W | Write data, captured at start |
| cr_ack_i | input | 1 | Acknowledge from the PHY port |
| cr_word_o | output | VAL_W+4 | Outgoing control word (value and strobes) |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle pulse: write committed |
| err_o | output | 1 | One-cycle pulse: acknowledge wait timed out |

## Verification
The hardest conditions to reach from the ports are a timeout on the acknowledge-low edge of a late phase, and an acknowledge that lands exactly in the last cycle of a wait window. The bench's responder model takes a per-test delay and a per-phase, per-edge refusal to respond. It can therefore hold the acknowledge high forever after the data capture, or never answer the commit strobe. With the poll divider shrunk so that a window is 20 cycles, acknowledge delays of 20 and 21 cycles land just inside and just outside the bound. A logger records each change of the outgoing word and how long it held, so the checks read off the phase order, the one-cycle lead-in and the timeout length.

// File: rtl/crp_pkg.sv
package crp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_SET  = 2'd2,
    ST_CLR  = 2'd3
  } crp_state_e;

  typedef enum logic [1:0] {
    PH_ADDR  = 2'd0,
    PH_DATA  = 2'd1,
    PH_WRITE = 2'd2
  } crp_phase_e;

endpackage

// File: rtl/crp_rst_sync.sv
module crp_rst_sync (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];

endmodule

// File: rtl/crp_poll_timer.sv
module crp_poll_timer #(
  parameter int unsigned TICK_DIV   = 50,
  parameter int unsigned POLL_LIMIT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic restart_i,
  output logic expire_o
);

  localparam int unsigned DIV_W = $clog2(TICK_DIV + 1);
  localparam int unsigned LIM_W = $clog2(POLL_LIMIT + 1);

  logic             tick;
  logic             cnt_en;
  logic [LIM_W-1:0] poll_q, poll_n;

  assign cnt_en = run_i || restart_i;

  // Poll tick: divided clock when TICK_DIV > 1, every cycle otherwise
  if (TICK_DIV > 1) begin : g_div
    logic [DIV_W-1:0] div_q, div_n;

    always_comb begin
      if (restart_i || !run_i)                  div_n = '0;
      else if (div_q == DIV_W'(TICK_DIV - 1))   div_n = '0;
      else                                      div_n = div_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      div_q <= '0;
      else if (cnt_en) div_q <= div_n;
    end

    assign tick = run_i && (div_q == DIV_W'(TICK_DIV - 1));
  end else begin : g_nodiv
    assign tick = run_i;
  end

  always_comb begin
    if (restart_i || !run_i) poll_n = '0;
    else if (tick)           poll_n = poll_q + 1'b1;
    else                     poll_n = poll_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      poll_q <= '0;
    else if (cnt_en) poll_q <= poll_n;
  end

  assign expire_o = tick && (poll_q == LIM_W'(POLL_LIMIT - 1));

  // R5: the tick count of a wait never passes its limit
  assert_poll_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (poll_q <= LIM_W'(POLL_LIMIT - 1)));

endmodule

// File: rtl/crp_seq.sv
module crp_seq
  import crp_pkg::*;
#(
  parameter int unsigned VAL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [VAL_W-1:0] addr_i,
  input  logic [VAL_W-1:0] data_i,
  input  logic             ack_i,
  input  logic             expire_i,
  output logic             run_o,
  output logic             restart_o,
  output logic [VAL_W+3:0] word_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);

  crp_state_e       state_q, state_n;
  crp_phase_e       phase_q, phase_n;
  logic [VAL_W-1:0] addr_q, data_q, val;
  logic             ld;
  logic             done_q, done_n, err_q, err_n;
  logic             cmd_a, cmd_d, cmd_w;

  // Next-state logic
  always_comb begin
    state_n = state_q;
    phase_n = phase_q;
    ld      = 1'b0;
    done_n  = 1'b0;
    err_n   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          ld      = 1'b1;
          phase_n = PH_ADDR;
          state_n = ST_PRE;
        end
      end
      ST_PRE: state_n = ST_SET;
      ST_SET: begin
        if (ack_i) begin
          state_n = ST_CLR;
        end else if (expire_i) begin
          state_n = ST_IDLE;
          err_n   = 1'b1;
        end
      end
      ST_CLR: begin
        if (!ack_i) begin
          case (phase_q)
            PH_ADDR: begin
              phase_n = PH_DATA;
              state_n = ST_PRE;
            end
            PH_DATA: begin
              phase_n = PH_WRITE;
              state_n = ST_SET;
            end
            default: begin
              state_n = ST_IDLE;
              done_n  = 1'b1;
            end
          endcase
        end else if (expire_i) begin
          state_n = ST_IDLE;
          err_n   = 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= PH_ADDR;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      phase_q <= phase_n;
      done_q  <= done_n;
      err_q   <= err_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (ld) begin
      addr_q <= addr_i;
      data_q <= data_i;
    end
  end

  // Outgoing word
  always_comb begin
    val   = (phase_q == PH_ADDR) ? addr_q : data_q;
    cmd_a = 1'b0;
    cmd_d = 1'b0;
    cmd_w = 1'b0;
    if (state_q == ST_SET) begin
      case (phase_q)
        PH_ADDR: cmd_a = 1'b1;
        PH_DATA: cmd_d = 1'b1;
        default: cmd_w = 1'b1;
      endcase
    end
    if (state_q == ST_IDLE) word_o = '0;
    else                    word_o = {cmd_w, 1'b0, val, cmd_d, cmd_a};
  end

  assign run_o     = (state_q == ST_SET) || (state_q == ST_CLR);
  assign restart_o = (state_n != state_q);
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign err_o     = err_q;

  // R8: captured operands hold for the whole transaction
  assert_val_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> ($stable(addr_q) && $stable(data_q)));

  // R2: completion only follows the commit phase
  assert_done_after_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(phase_q == PH_WRITE));

  // R7: completion pulses last one cycle
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q || err_q) |=> !(done_q || err_q));

endmodule

// File: rtl/crp_write_master.sv
module crp_write_master #(
  parameter int unsigned VAL_W      = 16,
  parameter int unsigned TICK_DIV   = 50,
  parameter int unsigned POLL_LIMIT = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [VAL_W-1:0] addr_i,
  input  logic [VAL_W-1:0] data_i,
  input  logic             cr_ack_i,
  output logic [VAL_W+3:0] cr_word_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);

  localparam int unsigned WORD_W = VAL_W + 4;
  localparam int unsigned WR_BIT = WORD_W - 1;

  logic rst_n_s;
  logic run, restart, expire;

  crp_rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n_a (rst_n),
    .rst_n_s (rst_n_s)
  );

  crp_poll_timer #(
    .TICK_DIV   (TICK_DIV),
    .POLL_LIMIT (POLL_LIMIT)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .run_i     (run),
    .restart_i (restart),
    .expire_o  (expire)
  );

  crp_seq #(
    .VAL_W (VAL_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .start_i   (start_i),
    .addr_i    (addr_i),
    .data_i    (data_i),
    .ack_i     (cr_ack_i),
    .expire_i  (expire),
    .run_o     (run),
    .restart_o (restart),
    .word_o    (cr_word_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .err_o     (err_o)
  );

  // R1: never two strobes at once
  assert_one_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0({cr_word_o[WR_BIT], cr_word_o[1], cr_word_o[0]}));

  // R4: an unanswered strobe stays up unless the wait times out
  assert_strobe_hold_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((cr_word_o[WR_BIT] || cr_word_o[1] || cr_word_o[0]) && !cr_ack_i)
      |=> ((cr_word_o[WR_BIT] || cr_word_o[1] || cr_word_o[0]) || err_o));

  // R7: done and error never coincide
  assert_done_err_excl_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(done_o && err_o));

  // R6 / R7: on completion the port is released and busy is low
  assert_end_idle_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done_o || err_o) |-> (!busy_o && (cr_word_o == '0)));

endmodule

// File: tb/crp_write_master_tb.sv
module crp_write_master_tb;

  localparam int VW    = 16;
  localparam int DIV   = 4;
  localparam int LIM   = 5;
  localparam int NWAIT = DIV * LIM;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [VW-1:0] addr, data;
  logic          ack;
  logic [VW+3:0] word;
  logic          busy, done, err;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  crp_write_master #(.VAL_W(VW), .TICK_DIV(DIV), .POLL_LIMIT(LIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr), .data_i(data),
    .cr_ack_i(ack), .cr_word_o(word), .busy_o(busy), .done_o(done), .err_o(err)
  );

  function automatic logic [VW+3:0] wv(input logic [VW-1:0] v, input int c);
    logic [VW+3:0] w;
    w = {2'b00, v, 2'b00};
    if (c == 1) w[0] = 1'b1;
    if (c == 2) w[1] = 1'b1;
    if (c == 3) w[VW+3] = 1'b1;
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Responder model: acks after rsp_dly cycles, optionally never on one edge of one phase
  int rsp_dly, hang_ph, last_ph, rcnt;
  bit hang_fall;
  always @(negedge clk) begin
    int cur;
    cur = word[0] ? 1 : word[1] ? 2 : word[VW+3] ? 3 : 0;
    if (!rst_n) begin
      ack = 1'b0;
      rcnt = 0;
    end else if (!ack) begin
      if (cur != 0 && !(hang_ph == cur && !hang_fall)) begin
        rcnt++;
        if (rcnt >= rsp_dly) begin ack = 1'b1; rcnt = 0; last_ph = cur; end
      end else rcnt = 0;
    end else begin
      if (cur == 0 && !(hang_ph == last_ph && hang_fall)) begin
        rcnt++;
        if (rcnt >= rsp_dly) begin ack = 1'b0; rcnt = 0; end
      end else rcnt = 0;
    end
  end

  // Logger: each distinct word and the number of cycles it held
  logic [VW+3:0] lw [16];
  int            ll [16];
  int            nl;
  logic [VW+3:0] lastw;
  bit            read_seen;
  always @(negedge clk) begin
    if (rst_n) begin
      if (word[VW+2]) read_seen = 1'b1;
      if (word !== lastw) begin
        if (nl < 16) begin lw[nl] = word; ll[nl] = 1; end
        nl++;
        lastw = word;
      end else if (nl > 0 && nl <= 16) ll[nl-1]++;
    end
  end

  logic [VW+3:0] ew [16];
  int            en;

  task automatic chk_seq(input string req);
    chk(nl == en, req, "word change count", nl, en);
    for (int i = 0; i < en && i < nl && i < 16; i++)
      chk(lw[i] === ew[i], req, $sformatf("word entry %0d", i), lw[i], ew[i]);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0; addr = '0; data = '0;
    hang_ph = 0; hang_fall = 1'b0; rsp_dly = 1;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
  endtask

  // Runs one transaction; res 1 = done, 2 = error, 0 = none
  task automatic run_write(input logic [VW-1:0] a, input logic [VW-1:0] d,
                           input int late, output int res);
    int busy_bad;
    nl = 0; lastw = '0; read_seen = 1'b0; busy_bad = 0; res = 0;
    @(posedge clk); #1 addr = a; data = d; start = 1'b1;
    @(posedge clk); #1 start = 1'b0; addr = ~a; data = ~d;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk); #1;
      if (late != 0 && c == late) begin start = 1'b1; addr = 16'h1234; data = 16'h4321; end
      if (late != 0 && c == late + 1) start = 1'b0;
      if (done || err) begin
        res = done ? 1 : 2;
        chk(!(done && err), "R7", "done and error together", {done, err}, 2'b00);
        chk(!busy, "R7", "busy at completion pulse", busy, 0);
        break;
      end
      if (!busy) busy_bad++;
    end
    chk(busy_bad == 0, "R7", "busy dropped early", busy_bad, 0);
    @(negedge clk); #1;
    chk(!done && !err, "R7", "pulse width", {done, err}, 2'b00);
    chk(word == '0, "R6", "word after completion", word, 0);
    chk(!read_seen, "R1", "read strobe seen", read_seen, 0);
  endtask

  task automatic t_reset();
    do_reset();
    chk(word == '0, "R9", "word after reset", word, 0);
    chk(!busy, "R9", "busy after reset", busy, 0);
    chk(!done, "R9", "done after reset", done, 0);
    chk(!err, "R9", "error after reset", err, 0);
  endtask

  task automatic t_basic();
    int res;
    logic [VW-1:0] a, d;
    a = 16'h0015; d = 16'hA0E3;
    do_reset();
    run_write(a, d, 0, res);
    chk(res == 1, "R2", "basic write outcome", res, 1);
    ew[0] = wv(a, 0); ew[1] = wv(a, 1); ew[2] = wv(a, 0);
    ew[3] = wv(d, 0); ew[4] = wv(d, 2); ew[5] = wv(d, 0);
    ew[6] = wv(d, 3); ew[7] = wv(d, 0); ew[8] = '0; en = 9;
    chk_seq("R2");
    chk(ll[0] == 1, "R3", "lead-in before address capture", ll[0], 1);
    chk(ll[3] == 1, "R3", "lead-in before data capture", ll[3], 1);
    chk(ll[5] == 1, "R3", "no lead-in before commit", ll[5], 1);
  endtask

  task automatic t_slow();
    int res;
    logic [VW-1:0] a, d;
    a = 16'hFFFF; d = 16'h8001;
    do_reset();
    rsp_dly = 3;
    run_write(a, d, 0, res);
    chk(res == 1, "R4", "slow responder outcome", res, 1);
    ew[0] = wv(a, 0); ew[1] = wv(a, 1); ew[2] = wv(a, 0);
    ew[3] = wv(d, 0); ew[4] = wv(d, 2); ew[5] = wv(d, 0);
    ew[6] = wv(d, 3); ew[7] = wv(d, 0); ew[8] = '0; en = 9;
    chk_seq("R1");
    chk(ll[1] == 3, "R4", "strobe held until ack high", ll[1], 3);
    chk(ll[2] == 3, "R4", "value held until ack low", ll[2], 3);
    chk(ll[7] == 3, "R4", "commit release held", ll[7], 3);
  endtask

  task automatic t_bound_ok();
    int res;
    do_reset();
    rsp_dly = NWAIT;
    run_write(16'h0102, 16'h0304, 0, res);
    chk(res == 1, "R5", "ack in last window cycle", res, 1);
    chk(ll[1] == NWAIT, "R5", "strobe duration at bound", ll[1], NWAIT);
  endtask

  task automatic t_bound_to();
    int res;
    logic [VW-1:0] a;
    a = 16'h0A0B;
    do_reset();
    rsp_dly = NWAIT + 1;
    run_write(a, 16'h0C0D, 0, res);
    chk(res == 2, "R5", "ack one cycle late times out", res, 2);
    ew[0] = wv(a, 0); ew[1] = wv(a, 1); ew[2] = '0; en = 3;
    chk_seq("R6");
    chk(ll[1] == NWAIT, "R5", "timeout window length", ll[1], NWAIT);
  endtask

  task automatic t_hang_data_fall();
    int res;
    logic [VW-1:0] a, d;
    a = 16'h0033; d = 16'h7700;
    do_reset();
    hang_ph = 2; hang_fall = 1'b1;
    run_write(a, d, 0, res);
    chk(res == 2, "R6", "stuck-high ack in data phase", res, 2);
    ew[0] = wv(a, 0); ew[1] = wv(a, 1); ew[2] = wv(a, 0);
    ew[3] = wv(d, 0); ew[4] = wv(d, 2); ew[5] = wv(d, 0); ew[6] = '0; en = 7;
    chk_seq("R6");
    chk(ll[5] == NWAIT, "R5", "release wait length", ll[5], NWAIT);
  endtask

  task automatic t_hang_write_rise();
    int res;
    logic [VW-1:0] a, d;
    a = 16'h4444; d = 16'h5555;
    do_reset();
    hang_ph = 3; hang_fall = 1'b0;
    run_write(a, d, 0, res);
    chk(res == 2, "R6", "unanswered commit", res, 2);
    ew[0] = wv(a, 0); ew[1] = wv(a, 1); ew[2] = wv(a, 0);
    ew[3] = wv(d, 0); ew[4] = wv(d, 2); ew[5] = wv(d, 0);
    ew[6] = wv(d, 3); ew[7] = '0; en = 8;
    chk_seq("R6");
    chk(ll[6] == NWAIT, "R5", "commit strobe wait length", ll[6], NWAIT);
  endtask

  task automatic t_busy_start();
    int res;
    logic [VW-1:0] a, d;
    a = 16'h00F0; d = 16'h0F0F;
    do_reset();
    rsp_dly = 2;
    run_write(a, d, 3, res);
    chk(res == 1, "R8", "write with start while busy", res, 1);
    ew[0] = wv(a, 0); ew[1] = wv(a, 1); ew[2] = wv(a, 0);
    ew[3] = wv(d, 0); ew[4] = wv(d, 2); ew[5] = wv(d, 0);
    ew[6] = wv(d, 3); ew[7] = wv(d, 0); ew[8] = '0; en = 9;
    chk_seq("R8");
    repeat (10) @(negedge clk);
    #1;
    chk(!busy && word == '0, "R8", "no second transaction", {busy, word}, 0);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    nl = 0; lastw = '0; read_seen = 1'b0; ack = 1'b0; rcnt = 0; last_ph = 0;
    t_reset();
    t_basic();
    t_slow();
    t_bound_ok();
    t_bound_to();
    t_hang_data_fall();
    t_hang_write_rise();
    t_busy_start();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule